// File: doc/BRIEF.md
# Coexistence Active Request Controller

This block drives the medium-request line that a packet radio raises toward an external arbiter when it shares the air with another transceiver. The radio asks for the medium with a level request. The block asserts the external line at once. When the radio is the master of the link, the block then counts a programmed setup time. It reports through `setup_done` when the packet may start. A slave radio cannot move the packet, so it is reported ready at once.

If the radio withdraws its request while a transmit packet is on the air, the line is dropped at once. A bounded abort countdown starts, and it ends in a one-cycle truncation pulse to the radio. If the packet ends before the countdown expires, the countdown is abandoned silently. Receive packets and transmissions with aborting disabled are never truncated: the line is held until the packet ends.

All timing runs on a microsecond tick derived from the kernel clock. The setup time and abort delay are sampled when a request starts. They are clamped to their legal ranges, and any out-of-range value sets a sticky error flag.

Top module: `coex_req_top`

## Requirements
- R1: After reset, `req_pin` sits at its inactive level (equal to `cfg_act_low`), and `setup_done`, `abort_pulse` and `cfg_err` are all 0.
- R2: Every timed interval is a whole number of microseconds, where one microsecond is CLK_PER_US kernel clock cycles. The microsecond count restarts at the first edge of each interval.
- R3: In master role (`is_master`=1), the line goes active on the edge that samples `radio_req` high. `setup_done` rises exactly setup×CLK_PER_US cycles later and stays high while the request is held.
- R4: In slave role (`is_master`=0), `setup_done` rises on the same edge as the line, with no setup wait.
- R5: Dropping `radio_req` while no packet is detected releases the line and clears `setup_done` on the next edge, even during the setup wait.
- R6: Dropping `radio_req` during a detected transmit packet (`is_tx`=1) with `cfg_abort_dis`=0 releases the line on the next edge. `abort_pulse` is then high for exactly one cycle, abort×CLK_PER_US cycles after that edge.
- R7: If `pkt_det` falls before the abort countdown expires, no `abort_pulse` is produced.
- R8: A withdrawal during a receive packet, or during any packet while `cfg_abort_dis`=1, holds the line active with `setup_done` low until `pkt_det` falls. The line is released on the next edge and no pulse is produced.
- R9: The active level of `req_pin` is 1 when `cfg_act_low`=0 and 0 when `cfg_act_low`=1. The idle level follows `cfg_act_low` one cycle later.
- R10: At request start, setup values outside 20..150 µs and abort values outside 5..10 µs are clamped to the nearest bound. `cfg_err` is set on that edge and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| radio_req | input | 1 | Radio activation request (level) |
| pkt_det | input | 1 | High while a packet is on the air |
| is_master | input | 1 | 1: radio controls packet timing; 0: peer does |
| is_tx | input | 1 | 1: current packet is a transmission |
| cfg_setup_us | input | 8 | Request-to-packet setup time in µs |
| cfg_abort_us | input | 4 | Transmit abort delay in µs |
| cfg_act_low | input | 1 | Request line sense: 0 active high, 1 active low |
| cfg_abort_dis | input | 1 | 1: withdrawal never truncates a transmission |
| req_pin | output | 1 | External medium-request line |
| setup_done | output | 1 | Setup time met, packet may proceed |
| abort_pulse | output | 1 | One-cycle truncation command to the radio |
| cfg_err | output | 1 | Sticky out-of-range configuration flag |

## Verification
The bench places checks on both sides of each deadline: one cycle before and on the cycle the setup time and abort delay expire. An off-by-one tick or a prescaler that does not restart would therefore move `setup_done` or `abort_pulse` by a cycle and be caught. A packet is ended partway into the abort countdown to catch a design that still fires the pulse. Receive packets and the abort-disable setting are checked for a line that is held rather than dropped, because a wrong design would release it early or truncate the packet. Clamping is checked with values both below and above the legal ranges, measured by the timing that results. The error flag is then checked for staying set through later legal requests.

// File: rtl/coex_req_pkg.sv
package coex_req_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_READY = 3'd2,
    ST_HOLD  = 3'd3,
    ST_ABORT = 3'd4
  } coex_state_e;
endpackage

// File: rtl/coex_tick_gen.sv
module coex_tick_gen #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/coex_us_counter.sv
module coex_us_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt_q;
  logic [W:0]   nxt;

  assign nxt  = {1'b0, cnt_q} + 1'b1;
  assign done = tick && (nxt == {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= nxt[W-1:0];
  end
endmodule

// File: rtl/coex_cfg_check.sv
module coex_cfg_check #(
  parameter int W  = 8,
  parameter int LO = 20,
  parameter int HI = 150
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] clamped,
  output logic         bad
);
  localparam logic [W-1:0] LO_V = W'(LO);
  localparam logic [W-1:0] HI_V = W'(HI);

  always_comb begin
    bad     = 1'b1;
    clamped = val;
    if (val < LO_V)      clamped = LO_V;
    else if (val > HI_V) clamped = HI_V;
    else                 bad     = 1'b0;
  end
endmodule

// File: rtl/coex_req_top.sv
module coex_req_top
  import coex_req_pkg::*;
#(
  parameter int CLK_PER_US = 100,
  parameter int SETUP_W    = 8,
  parameter int ABORT_W    = 4,
  parameter int SETUP_MIN  = 20,
  parameter int SETUP_MAX  = 150,
  parameter int ABORT_MIN  = 5,
  parameter int ABORT_MAX  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               radio_req,
  input  logic               pkt_det,
  input  logic               is_master,
  input  logic               is_tx,
  input  logic [SETUP_W-1:0] cfg_setup_us,
  input  logic [ABORT_W-1:0] cfg_abort_us,
  input  logic               cfg_act_low,
  input  logic               cfg_abort_dis,
  output logic               req_pin,
  output logic               setup_done,
  output logic               abort_pulse,
  output logic               cfg_err
);
  localparam int CNT_W = (SETUP_W > ABORT_W) ? SETUP_W : ABORT_W;

  coex_state_e        state_q, state_d;
  logic [SETUP_W-1:0] setup_lim_q, setup_cl;
  logic [ABORT_W-1:0] abort_lim_q, abort_cl;
  logic [CNT_W-1:0]   cnt_lim;
  logic               setup_bad, abort_bad;
  logic               start, clr, tick, cnt_done, fire, act_d;
  logic               req_pin_q, done_q, abort_q, err_q;

  coex_cfg_check #(.W(SETUP_W), .LO(SETUP_MIN), .HI(SETUP_MAX)) u_setup_chk (
    .val(cfg_setup_us), .clamped(setup_cl), .bad(setup_bad)
  );

  coex_cfg_check #(.W(ABORT_W), .LO(ABORT_MIN), .HI(ABORT_MAX)) u_abort_chk (
    .val(cfg_abort_us), .clamped(abort_cl), .bad(abort_bad)
  );

  coex_tick_gen #(.DIV(CLK_PER_US)) u_tick (
    .clk(clk), .rst(rst), .clr(clr), .tick(tick)
  );

  assign cnt_lim = (state_q == ST_ABORT) ? CNT_W'(abort_lim_q) : CNT_W'(setup_lim_q);

  coex_us_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr), .tick(tick), .limit(cnt_lim), .done(cnt_done)
  );

  assign start = (state_q == ST_IDLE) && radio_req;
  assign fire  = (state_q == ST_ABORT) && pkt_det && cnt_done;
  assign clr   = (state_d != state_q) && ((state_d == ST_SETUP) || (state_d == ST_ABORT));
  assign act_d = (state_d == ST_SETUP) || (state_d == ST_READY) || (state_d == ST_HOLD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (radio_req) state_d = is_master ? ST_SETUP : ST_READY;
      ST_SETUP: if (!radio_req) state_d = ST_IDLE;
                else if (cnt_done) state_d = ST_READY;
      ST_READY: if (!radio_req) begin
                  if (!pkt_det) state_d = ST_IDLE;
                  else if (is_tx && !cfg_abort_dis) state_d = ST_ABORT;
                  else state_d = ST_HOLD;
                end
      ST_HOLD:  if (!pkt_det) state_d = ST_IDLE;
      ST_ABORT: if (!pkt_det || cnt_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      setup_lim_q <= SETUP_W'(SETUP_MIN);
      abort_lim_q <= ABORT_W'(ABORT_MIN);
      req_pin_q   <= cfg_act_low;
      done_q      <= 1'b0;
      abort_q     <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q   <= state_d;
      req_pin_q <= cfg_act_low ^ act_d;
      done_q    <= (state_d == ST_READY);
      abort_q   <= fire;
      if (start) begin
        setup_lim_q <= setup_cl;
        abort_lim_q <= abort_cl;
        err_q       <= err_q | setup_bad | abort_bad;
      end
    end
  end

  assign req_pin     = req_pin_q;
  assign setup_done  = done_q;
  assign abort_pulse = abort_q;
  assign cfg_err     = err_q;
endmodule

// File: rtl/coex_req_chk.sv
module coex_req_chk (
  input logic clk,
  input logic rst,
  input logic radio_req,
  input logic cfg_act_low,
  input logic req_pin,
  input logic setup_done,
  input logic abort_pulse,
  input logic cfg_err
);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |=> !abort_pulse);

  a_r6_line_released: assert property (@(posedge clk) disable iff (rst)
    (abort_pulse && $stable(cfg_act_low)) |-> (req_pin == cfg_act_low));

  a_r6_no_pulse_when_ready: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |-> !setup_done);

  a_r3_ready_line_active: assert property (@(posedge clk) disable iff (rst)
    (setup_done && $stable(cfg_act_low)) |-> (req_pin != cfg_act_low));

  a_r5_ready_needs_request: assert property (@(posedge clk) disable iff (rst)
    setup_done |-> $past(radio_req));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
endmodule

bind coex_req_top coex_req_chk u_chk (
  .clk(clk), .rst(rst), .radio_req(radio_req), .cfg_act_low(cfg_act_low),
  .req_pin(req_pin), .setup_done(setup_done), .abort_pulse(abort_pulse),
  .cfg_err(cfg_err)
);

// File: tb/coex_req_top_test.sv
module coex_req_top_test;
  localparam int D = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       radio_req = 1'b0, pkt_det = 1'b0, is_master = 1'b1, is_tx = 1'b1;
  logic [7:0] cfg_setup_us = 8'd20;
  logic [3:0] cfg_abort_us = 4'd5;
  logic       cfg_act_low = 1'b0, cfg_abort_dis = 1'b0;
  logic       req_pin, setup_done, abort_pulse, cfg_err;

  coex_req_top #(.CLK_PER_US(D)) uut (
    .clk(clk), .rst(rst), .radio_req(radio_req), .pkt_det(pkt_det),
    .is_master(is_master), .is_tx(is_tx), .cfg_setup_us(cfg_setup_us),
    .cfg_abort_us(cfg_abort_us), .cfg_act_low(cfg_act_low),
    .cfg_abort_dis(cfg_abort_dis), .req_pin(req_pin), .setup_done(setup_done),
    .abort_pulse(abort_pulse), .cfg_err(cfg_err)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    bit    pin;
    bit    done;
    bit    ab;
    bit    err;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_err = 0;
  bit   err_exp = 1'b0;
  bit   finished = 1'b0;

  // driver side: expected outputs, offset cycles after the current negedge
  task automatic expect_at(int off, bit act, bit done, bit ab, string tag);
    exp_t e;
    e.at = cyc + off; e.pin = act ^ cfg_act_low; e.done = done;
    e.ab = ab; e.err = err_exp; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop and compare when the scheduled cycle arrives
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (e.at != cyc || req_pin !== e.pin || setup_done !== e.done ||
          abort_pulse !== e.ab || cfg_err !== e.err) begin
        n_err++;
        $display("FAIL %s cyc=%0d pin/done/abort/err actual=%b%b%b%b expected=%b%b%b%b",
                 e.tag, cyc, req_pin, setup_done, abort_pulse, cfg_err,
                 e.pin, e.done, e.ab, e.err);
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    expect_at(1, 0, 0, 0, "R1");
    wait_n(3);

    // R3/R2 master setup, packet, then plain release (R5)
    radio_req = 1'b1;
    expect_at(1, 1, 0, 0, "R3");
    expect_at(20*D, 1, 0, 0, "R2");
    expect_at(20*D+1, 1, 1, 0, "R3");
    wait_n(20*D+1);
    pkt_det = 1'b1;
    expect_at(1, 1, 1, 0, "R3");
    wait_n(20); pkt_det = 1'b0; wait_n(5);
    radio_req = 1'b0;
    expect_at(1, 0, 0, 0, "R5");
    wait_n(3);

    // R5 withdrawal during the setup wait
    radio_req = 1'b1; wait_n(50);
    radio_req = 1'b0;
    expect_at(1, 0, 0, 0, "R5");
    expect_at(20*D, 0, 0, 0, "R5");
    wait_n(20*D+2);

    // R4 slave, R8 receive packet hold
    is_master = 1'b0;
    radio_req = 1'b1;
    expect_at(1, 1, 1, 0, "R4");
    wait_n(2);
    is_tx = 1'b0; pkt_det = 1'b1; wait_n(10);
    radio_req = 1'b0;
    expect_at(1, 1, 0, 0, "R8");
    wait_n(15);
    pkt_det = 1'b0;
    expect_at(1, 0, 0, 0, "R8");
    wait_n(3);
    is_master = 1'b1; is_tx = 1'b1;

    // R6 transmit abort with 5 us delay
    radio_req = 1'b1; wait_n(20*D+1);
    pkt_det = 1'b1; wait_n(5);
    radio_req = 1'b0;
    expect_at(1, 0, 0, 0, "R6");
    expect_at(5*D, 0, 0, 0, "R6");
    expect_at(5*D+1, 0, 0, 1, "R6");
    expect_at(5*D+2, 0, 0, 0, "R6");
    wait_n(5*D+5);
    pkt_det = 1'b0; wait_n(3);

    // R7 packet ends before a 10 us countdown
    cfg_abort_us = 4'd10;
    radio_req = 1'b1; wait_n(20*D+1);
    pkt_det = 1'b1; wait_n(5);
    radio_req = 1'b0;
    expect_at(1, 0, 0, 0, "R7");
    wait_n(30);
    pkt_det = 1'b0;
    expect_at(1, 0, 0, 0, "R7");
    expect_at(70, 0, 0, 0, "R7");
    expect_at(71, 0, 0, 0, "R7");
    expect_at(72, 0, 0, 0, "R7");
    wait_n(80);

    // R8 abort disabled on a transmission
    cfg_abort_us = 4'd5; cfg_abort_dis = 1'b1;
    radio_req = 1'b1; wait_n(20*D+1);
    pkt_det = 1'b1; wait_n(5);
    radio_req = 1'b0;
    expect_at(1, 1, 0, 0, "R8");
    expect_at(5*D+1, 1, 0, 0, "R8");
    wait_n(5*D+10);
    pkt_det = 1'b0;
    expect_at(1, 0, 0, 0, "R8");
    wait_n(3);
    cfg_abort_dis = 1'b0;

    // R9 active-low sense
    cfg_act_low = 1'b1;
    expect_at(1, 0, 0, 0, "R9");
    wait_n(2);
    is_master = 1'b0; radio_req = 1'b1;
    expect_at(1, 1, 1, 0, "R9");
    wait_n(4);
    radio_req = 1'b0;
    expect_at(1, 0, 0, 0, "R9");
    wait_n(3);
    cfg_act_low = 1'b0; is_master = 1'b1;
    wait_n(2);

    // R10 clamping, low setup value
    cfg_setup_us = 8'd5;
    radio_req = 1'b1; err_exp = 1'b1;
    expect_at(1, 1, 0, 0, "R10");
    expect_at(20*D, 1, 0, 0, "R10");
    expect_at(20*D+1, 1, 1, 0, "R10");
    wait_n(20*D+1);
    radio_req = 1'b0;
    expect_at(1, 0, 0, 0, "R10");
    wait_n(3);

    // R10 clamping, high setup and abort values
    cfg_setup_us = 8'd200; cfg_abort_us = 4'd15;
    radio_req = 1'b1;
    expect_at(150*D, 1, 0, 0, "R10");
    expect_at(150*D+1, 1, 1, 0, "R10");
    wait_n(150*D+1);
    pkt_det = 1'b1; wait_n(2);
    radio_req = 1'b0;
    expect_at(10*D, 0, 0, 0, "R10");
    expect_at(10*D+1, 0, 0, 1, "R10");
    wait_n(10*D+4);
    pkt_det = 1'b0; wait_n(2);

    // R10 flag stays set on a later legal request; R2 with a new setup value
    cfg_setup_us = 8'd30; cfg_abort_us = 4'd5;
    radio_req = 1'b1;
    expect_at(1, 1, 0, 0, "R10");
    expect_at(30*D, 1, 0, 0, "R2");
    expect_at(30*D+1, 1, 1, 0, "R2");
    wait_n(30*D+2);
    radio_req = 1'b0;
    wait_n(3);

    if (q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R2 pending expectations actual=%0d expected=0", q.size());
    end
    finished = 1'b1;
    summary();
  end
endmodule